// File: doc/BRIEF.md
# Dual-Channel Lockstep Packet Joiner

This block sits between two packet streams and a pair of downstream consumers. Every stream word carries 64 data bits and an 8-bit control tag, and moves on a valid/ready handshake. A control tag of all ones marks the first word of a packet. A tag with exactly one bit set marks the final word. Any other tag marks a middle word.

When headers show up on both inputs in the same cycle, the two packets are joined and move forward word for word. If one of them finishes first, its output lane keeps running beside the longer packet. Each of those extra words has zero data and the control tag `0xF0`, which marks it as filler. When only one input starts a packet, that packet passes through alone. The other input is stalled until the packet ends, and the start decision is then made again.

The data path is purely combinational. The only register is the mode state, which is updated on the clock edge that ends a transfer cycle. Output valid is raised only in a cycle where the word actually moves, so an output valid always implies the matching output ready.

Top module: `lockstep_pad_arbiter`

## Requirements
- R1: While reset is active, both input readies and both output valids are low.
- R2: When both inputs present a header (control `0xFF`) in the same cycle while idle, both headers move together in one cycle once both output readies are high, and the block enters joined mode.
- R3: In joined mode, a word moves only when both inputs are valid and both outputs are ready. Each input ready equals the other input's valid ANDed with both output readies, and the two output valids are always equal.
- R4: When a header appears on only one input while idle, that packet passes alone. The other input's ready stays low until that packet's final word moves, and no word moves while the active lane's output ready is low.
- R5: A header held back on one input is re-evaluated in the cycle after the other packet's final word moves. It then starts its own packet.
- R6: When both joined packets end in the same cycle, the block returns to idle and emits no filler word.
- R7: When the first input ends before the second in joined mode, first-lane output words carry data 0 and control `0xF0` in every cycle where a second-lane word moves. The first input's ready stays low during this, and filling stops after the second packet's final word.
- R8: R7 holds with the two lanes swapped when the second input ends first.
- R9: While idle, a valid non-header word is accepted (ready high) and dropped (its output valid stays low).
- R10: Words that are not filler leave on their own lane with data and control unchanged.
- R11: Only a control value with exactly one bit set ends a packet. A value with two bits set (for example `0x03`) does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in_data | input | DATA_W | First input data |
| a_in_ctrl | input | CTRL_W | First input control tag |
| a_in_valid | input | 1 | First input word present |
| a_in_ready | output | 1 | First input word taken |
| b_in_data | input | DATA_W | Second input data |
| b_in_ctrl | input | CTRL_W | Second input control tag |
| b_in_valid | input | 1 | Second input word present |
| b_in_ready | output | 1 | Second input word taken |
| a_out_data | output | DATA_W | First lane output data |
| a_out_ctrl | output | CTRL_W | First lane output control tag |
| a_out_valid | output | 1 | First lane word moves this cycle |
| a_out_ready | input | 1 | First lane consumer can take a word |
| b_out_data | output | DATA_W | Second lane output data |
| b_out_ctrl | output | CTRL_W | Second lane output control tag |
| b_out_valid | output | 1 | Second lane word moves this cycle |
| b_out_ready | input | 1 | Second lane consumer can take a word |

## Verification
Readies, valids, data and control are combinational, so every one of them is due in the same cycle that its inputs are applied. Only the mode changes, and that change shows up in the cycle after the edge that closes a transfer. The bench drives inputs just after the falling edge. It compares all outputs against a behavioural model a quarter period later, before the rising edge. The model's mode is advanced only at that rising edge, so a decision taken on a header or a final word is checked in the very next cycle. Reset release passes through a two-stage synchroniser, and the bench leaves those cycles unchecked.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SOLO_A = 3'd1,
    ST_SOLO_B = 3'd2,
    ST_JOIN   = 3'd3,
    ST_FILL_A = 3'd4,
    ST_FILL_B = 3'd5
  } lsa_state_e;
endpackage

// File: rtl/lsa_rst_sync.sv
module lsa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsa_mark_decode.sv
module lsa_mark_decode #(
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              valid,
  output logic              is_head,
  output logic              is_tail
);
  // header: every control bit set; tail: exactly one control bit set
  assign is_head = valid && (ctrl == {CTRL_W{1'b1}});
  assign is_tail = valid && ($countones(ctrl) == 1);
endmodule

// File: rtl/lsa_lane_mux.sv
module lsa_lane_mux #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              move,
  input  logic              fill,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_valid
);
  localparam int HI_W = CTRL_W / 2;
  localparam logic [CTRL_W-1:0] FILL_CODE = {{HI_W{1'b1}}, {(CTRL_W-HI_W){1'b0}}};

  assign out_valid = move;
  assign out_data  = fill ? '0 : in_data;
  assign out_ctrl  = fill ? FILL_CODE : in_ctrl;
endmodule

// File: rtl/lsa_ctrl_fsm.sv
module lsa_ctrl_fsm
  import lsa_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic [1:0] in_valid,
  input  logic [1:0] head,
  input  logic [1:0] tail,
  input  logic [1:0] out_ready,
  output logic [1:0] in_ready,
  output logic [1:0] move,
  output logic [1:0] fill,
  output lsa_state_e state
);
  lsa_state_e st_q, st_nxt;
  logic       st_en;
  logic       both_out;
  logic       go;

  assign both_out = out_ready[0] & out_ready[1];

  always_comb begin
    st_nxt   = st_q;
    in_ready = 2'b00;
    move     = 2'b00;
    fill     = 2'b00;
    go       = 1'b0;
    if (srst_n) begin
      unique case (st_q)
        ST_IDLE: begin
          if (head[0] && head[1]) begin
            go       = both_out;
            in_ready = {go, go};
            move     = {go, go};
            if (go) st_nxt = ST_JOIN;
          end else if (head[0]) begin
            in_ready = {1'b1, out_ready[0]};
            move     = {1'b0, out_ready[0]};
            if (out_ready[0]) st_nxt = ST_SOLO_A;
          end else if (head[1]) begin
            in_ready = {out_ready[1], 1'b1};
            move     = {out_ready[1], 1'b0};
            if (out_ready[1]) st_nxt = ST_SOLO_B;
          end else begin
            in_ready = 2'b11;
          end
        end
        ST_SOLO_A: begin
          go       = in_valid[0] & out_ready[0];
          in_ready = {1'b0, out_ready[0]};
          move     = {1'b0, go};
          if (go && tail[0]) st_nxt = ST_IDLE;
        end
        ST_SOLO_B: begin
          go       = in_valid[1] & out_ready[1];
          in_ready = {out_ready[1], 1'b0};
          move     = {go, 1'b0};
          if (go && tail[1]) st_nxt = ST_IDLE;
        end
        ST_JOIN: begin
          go       = in_valid[0] & in_valid[1] & both_out;
          in_ready = {in_valid[0] & both_out, in_valid[1] & both_out};
          move     = {go, go};
          if (go) begin
            if (tail[0] && tail[1]) st_nxt = ST_IDLE;
            else if (tail[0])       st_nxt = ST_FILL_A;
            else if (tail[1])       st_nxt = ST_FILL_B;
          end
        end
        ST_FILL_A: begin
          go       = in_valid[1] & both_out;
          in_ready = {both_out, 1'b0};
          move     = {go, go};
          fill     = 2'b01;
          if (go && tail[1]) st_nxt = ST_IDLE;
        end
        ST_FILL_B: begin
          go       = in_valid[0] & both_out;
          in_ready = {1'b0, both_out};
          move     = {go, go};
          fill     = 2'b10;
          if (go && tail[0]) st_nxt = ST_IDLE;
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  assign st_en = (st_nxt != st_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    st_q <= ST_IDLE;
    else if (st_en) st_q <= st_nxt;
  end

  assign state = st_q;
endmodule

// File: rtl/lockstep_pad_arbiter.sv
module lockstep_pad_arbiter
  import lsa_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int CTRL_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in_data,
  input  logic [CTRL_W-1:0] a_in_ctrl,
  input  logic              a_in_valid,
  output logic              a_in_ready,
  input  logic [DATA_W-1:0] b_in_data,
  input  logic [CTRL_W-1:0] b_in_ctrl,
  input  logic              b_in_valid,
  output logic              b_in_ready,
  output logic [DATA_W-1:0] a_out_data,
  output logic [CTRL_W-1:0] a_out_ctrl,
  output logic              a_out_valid,
  input  logic              a_out_ready,
  output logic [DATA_W-1:0] b_out_data,
  output logic [CTRL_W-1:0] b_out_ctrl,
  output logic              b_out_valid,
  input  logic              b_out_ready
);
  localparam int LANES = 2;

  logic              srst_n;
  lsa_state_e        state;
  logic [DATA_W-1:0] ln_din  [LANES];
  logic [CTRL_W-1:0] ln_cin  [LANES];
  logic [DATA_W-1:0] ln_dout [LANES];
  logic [CTRL_W-1:0] ln_cout [LANES];
  logic [LANES-1:0]  ln_vin, ln_rdy_out, ln_rdy_in, ln_vout;
  logic [LANES-1:0]  ln_head, ln_tail, ln_move, ln_fill;

  assign ln_din[0]     = a_in_data;
  assign ln_din[1]     = b_in_data;
  assign ln_cin[0]     = a_in_ctrl;
  assign ln_cin[1]     = b_in_ctrl;
  assign ln_vin        = {b_in_valid, a_in_valid};
  assign ln_rdy_out    = {b_out_ready, a_out_ready};

  lsa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    lsa_mark_decode #(.CTRL_W(CTRL_W)) u_dec (
      .ctrl(ln_cin[ln]), .valid(ln_vin[ln]),
      .is_head(ln_head[ln]), .is_tail(ln_tail[ln])
    );
    lsa_lane_mux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_mux (
      .in_data(ln_din[ln]), .in_ctrl(ln_cin[ln]),
      .move(ln_move[ln]), .fill(ln_fill[ln]),
      .out_data(ln_dout[ln]), .out_ctrl(ln_cout[ln]), .out_valid(ln_vout[ln])
    );
  end

  lsa_ctrl_fsm u_fsm (
    .clk(clk), .srst_n(srst_n),
    .in_valid(ln_vin), .head(ln_head), .tail(ln_tail),
    .out_ready(ln_rdy_out), .in_ready(ln_rdy_in),
    .move(ln_move), .fill(ln_fill), .state(state)
  );

  assign a_in_ready  = ln_rdy_in[0];
  assign b_in_ready  = ln_rdy_in[1];
  assign a_out_data  = ln_dout[0];
  assign b_out_data  = ln_dout[1];
  assign a_out_ctrl  = ln_cout[0];
  assign b_out_ctrl  = ln_cout[1];
  assign a_out_valid = ln_vout[0];
  assign b_out_valid = ln_vout[1];
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker
  import lsa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input lsa_state_e        state,
  input logic [CTRL_W-1:0] a_in_ctrl,
  input logic              a_in_valid,
  input logic              a_in_ready,
  input logic [CTRL_W-1:0] b_in_ctrl,
  input logic              b_in_valid,
  input logic              b_in_ready,
  input logic [DATA_W-1:0] a_out_data,
  input logic [CTRL_W-1:0] a_out_ctrl,
  input logic              a_out_valid,
  input logic [DATA_W-1:0] b_out_data,
  input logic [CTRL_W-1:0] b_out_ctrl,
  input logic              b_out_valid
);
  localparam int HI_W = CTRL_W / 2;
  localparam logic [CTRL_W-1:0] FILL = {{HI_W{1'b1}}, {(CTRL_W-HI_W){1'b0}}};

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!a_in_ready && !b_in_ready && !a_out_valid && !b_out_valid)); // R1

  AST_JOIN_TWIN: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_JOIN) |-> (a_out_valid == b_out_valid)); // R3

  AST_JOIN_BOTH_TAKEN: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_JOIN && a_in_valid && a_in_ready) |-> (b_in_valid && b_in_ready)); // R3

  AST_SOLO_HOLD_B: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_SOLO_A) |-> !b_in_ready); // R4

  AST_SOLO_HOLD_A: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_SOLO_B) |-> !a_in_ready); // R4

  AST_EVEN_END: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_JOIN && a_out_valid && $countones(a_in_ctrl) == 1
      && $countones(b_in_ctrl) == 1) |=> (state == ST_IDLE)); // R6

  AST_FILL_A_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_FILL_A && a_out_valid) |-> (a_out_data == '0 && a_out_ctrl == FILL && b_out_valid)); // R7

  AST_FILL_B_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_FILL_B && b_out_valid) |-> (b_out_data == '0 && b_out_ctrl == FILL && a_out_valid)); // R8

  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE && a_in_valid && a_in_ctrl != {CTRL_W{1'b1}}) |-> (a_in_ready && !a_out_valid)); // R9
endmodule

bind lockstep_pad_arbiter lsa_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .state(state),
  .a_in_ctrl(a_in_ctrl), .a_in_valid(a_in_valid), .a_in_ready(a_in_ready),
  .b_in_ctrl(b_in_ctrl), .b_in_valid(b_in_valid), .b_in_ready(b_in_ready),
  .a_out_data(a_out_data), .a_out_ctrl(a_out_ctrl), .a_out_valid(a_out_valid),
  .b_out_data(b_out_data), .b_out_ctrl(b_out_ctrl), .b_out_valid(b_out_valid)
);

// File: tb/tb_lockstep_pad_arbiter.sv
module tb_lockstep_pad_arbiter;
  logic        clk;
  logic        rst_n;
  logic [63:0] a_in_data, b_in_data, a_out_data, b_out_data;
  logic [7:0]  a_in_ctrl, b_in_ctrl, a_out_ctrl, b_out_ctrl;
  logic        a_in_valid, b_in_valid, a_in_ready, b_in_ready;
  logic        a_out_valid, b_out_valid, a_out_ready, b_out_ready;

  int checks;
  int fails;
  int mode;
  int mode_nxt;
  bit in_reset;

  logic        e_ar, e_br, e_av, e_bv;
  logic [63:0] e_ad, e_bd;
  logic [7:0]  e_ac, e_bc;

  lockstep_pad_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .a_in_data(a_in_data), .a_in_ctrl(a_in_ctrl), .a_in_valid(a_in_valid), .a_in_ready(a_in_ready),
    .b_in_data(b_in_data), .b_in_ctrl(b_in_ctrl), .b_in_valid(b_in_valid), .b_in_ready(b_in_ready),
    .a_out_data(a_out_data), .a_out_ctrl(a_out_ctrl), .a_out_valid(a_out_valid), .a_out_ready(a_out_ready),
    .b_out_data(b_out_data), .b_out_ctrl(b_out_ctrl), .b_out_valid(b_out_valid), .b_out_ready(b_out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit is_head(input logic [7:0] c);
    return c == 8'hFF;
  endfunction

  function automatic bit is_tail(input logic [7:0] c);
    return (c != 8'h00) && ((c & (c - 8'd1)) == 8'h00);
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Mode codes: 0 idle, 1 first alone, 2 second alone, 3 joined, 4 first filling, 5 second filling
  task automatic model(input bit av, input logic [7:0] ac, input logic [63:0] ad,
                       input bit bv, input logic [7:0] bc, input logic [63:0] bd,
                       input bit xar, input bit xbr);
    bit ah, bh, go;
    e_ar = 0; e_br = 0; e_av = 0; e_bv = 0;
    e_ad = ad; e_ac = ac; e_bd = bd; e_bc = bc;
    mode_nxt = mode;
    if (in_reset) return;
    ah = av && is_head(ac);
    bh = bv && is_head(bc);
    case (mode)
      0: begin
        if (ah && bh) begin
          go = xar && xbr;
          e_ar = go; e_br = go; e_av = go; e_bv = go;
          if (go) mode_nxt = 3;
        end else if (ah) begin
          e_ar = xar; e_br = 1; e_av = xar;
          if (xar) mode_nxt = 1;
        end else if (bh) begin
          e_ar = 1; e_br = xbr; e_bv = xbr;
          if (xbr) mode_nxt = 2;
        end else begin
          e_ar = 1; e_br = 1;
        end
      end
      1: begin
        e_ar = xar; e_av = av && xar;
        if (av && xar && is_tail(ac)) mode_nxt = 0;
      end
      2: begin
        e_br = xbr; e_bv = bv && xbr;
        if (bv && xbr && is_tail(bc)) mode_nxt = 0;
      end
      3: begin
        go = av && bv && xar && xbr;
        e_ar = bv && xar && xbr; e_br = av && xar && xbr;
        e_av = go; e_bv = go;
        if (go) begin
          if (is_tail(ac) && is_tail(bc)) mode_nxt = 0;
          else if (is_tail(ac))          mode_nxt = 4;
          else if (is_tail(bc))          mode_nxt = 5;
        end
      end
      4: begin
        go = bv && xar && xbr;
        e_br = xar && xbr; e_av = go; e_bv = go;
        e_ad = '0; e_ac = 8'hF0;
        if (go && is_tail(bc)) mode_nxt = 0;
      end
      default: begin
        go = av && xar && xbr;
        e_ar = xar && xbr; e_av = go; e_bv = go;
        e_bd = '0; e_bc = 8'hF0;
        if (go && is_tail(ac)) mode_nxt = 0;
      end
    endcase
  endtask

  task automatic cyc(input string tag,
                     input bit av, input logic [7:0] ac, input logic [63:0] ad,
                     input bit bv, input logic [7:0] bc, input logic [63:0] bd,
                     input bit xar, input bit xbr);
    @(negedge clk);
    a_in_valid = av; a_in_ctrl = ac; a_in_data = ad;
    b_in_valid = bv; b_in_ctrl = bc; b_in_data = bd;
    a_out_ready = xar; b_out_ready = xbr;
    #5;
    model(av, ac, ad, bv, bc, bd, xar, xbr);
    check(tag, "a_in_ready", {63'd0, a_in_ready}, {63'd0, e_ar});
    check(tag, "b_in_ready", {63'd0, b_in_ready}, {63'd0, e_br});
    check(tag, "a_out_valid", {63'd0, a_out_valid}, {63'd0, e_av});
    check(tag, "b_out_valid", {63'd0, b_out_valid}, {63'd0, e_bv});
    if (e_av) begin
      check(tag, "a_out_data", a_out_data, e_ad);
      check(tag, "a_out_ctrl", {56'd0, a_out_ctrl}, {56'd0, e_ac});
    end
    if (e_bv) begin
      check(tag, "b_out_data", b_out_data, e_bd);
      check(tag, "b_out_ctrl", {56'd0, b_out_ctrl}, {56'd0, e_bc});
    end
    @(posedge clk);
    mode = mode_nxt;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; mode = 0; in_reset = 1;
    rst_n = 1'b0;
    a_in_valid = 0; b_in_valid = 0; a_in_ctrl = 0; b_in_ctrl = 0;
    a_in_data = 0; b_in_data = 0; a_out_ready = 0; b_out_ready = 0;
    // R1 reset quiet even with headers offered
    cyc("R1", 1, 8'hFF, 64'h11, 1, 8'hFF, 64'h22, 1, 1);
    cyc("R1", 1, 8'hFF, 64'h11, 1, 8'hFF, 64'h22, 1, 1);
    @(negedge clk);
    a_in_valid = 0; b_in_valid = 0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    in_reset = 0;

    // R2 R10 R6 equal-length joined packets
    cyc("R2",  1, 8'hFF, 64'hA000, 1, 8'hFF, 64'hB000, 1, 1);
    cyc("R10", 1, 8'h00, 64'hA001, 1, 8'h00, 64'hB001, 1, 1);
    cyc("R6",  1, 8'h01, 64'hA002, 1, 8'h02, 64'hB002, 1, 1);
    cyc("R6",  0, 8'h00, 64'h0,    0, 8'h00, 64'h0,    1, 1);

    // R3 stalls inside joined mode
    cyc("R2", 1, 8'hFF, 64'hA100, 1, 8'hFF, 64'hB100, 1, 0);
    cyc("R2", 1, 8'hFF, 64'hA100, 1, 8'hFF, 64'hB100, 1, 1);
    cyc("R3", 1, 8'h00, 64'hA101, 0, 8'h00, 64'h0,    1, 1);
    cyc("R3", 1, 8'h00, 64'hA101, 1, 8'h00, 64'hB101, 0, 1);
    cyc("R3", 1, 8'h00, 64'hA101, 1, 8'h00, 64'hB101, 1, 1);

    // R7 first lane ends early and is filled
    cyc("R7", 1, 8'h80, 64'hA102, 1, 8'h00, 64'hB102, 1, 1);
    cyc("R7", 1, 8'hFF, 64'hDEAD, 1, 8'h00, 64'hB103, 1, 1);
    cyc("R7", 0, 8'h00, 64'h0,    0, 8'h00, 64'h0,    1, 1);
    cyc("R7", 0, 8'h00, 64'h0,    1, 8'h04, 64'hB104, 1, 1);
    cyc("R7", 0, 8'h00, 64'h0,    0, 8'h00, 64'h0,    1, 1);

    // R8 second lane ends early and is filled
    cyc("R8", 1, 8'hFF, 64'hA200, 1, 8'hFF, 64'hB200, 1, 1);
    cyc("R8", 1, 8'h00, 64'hA201, 1, 8'h10, 64'hB201, 1, 1);
    cyc("R8", 1, 8'h00, 64'hA202, 1, 8'hFF, 64'hBEEF, 1, 1);
    cyc("R8", 1, 8'h00, 64'hA203, 0, 8'h00, 64'h0,    1, 0);
    cyc("R8", 1, 8'h20, 64'hA204, 0, 8'h00, 64'h0,    1, 1);

    // R4 R11 R5 single-lane packet with the other lane held
    cyc("R4",  1, 8'hFF, 64'hA300, 0, 8'h00, 64'h0,    0, 1);
    cyc("R4",  1, 8'hFF, 64'hA300, 0, 8'h00, 64'h0,    1, 1);
    cyc("R4",  1, 8'h00, 64'hA301, 1, 8'hFF, 64'hB300, 1, 1);
    cyc("R11", 1, 8'h03, 64'hA302, 1, 8'hFF, 64'hB300, 1, 1);
    cyc("R4",  1, 8'h00, 64'hA303, 1, 8'hFF, 64'hB300, 0, 1);
    cyc("R5",  1, 8'h40, 64'hA304, 1, 8'hFF, 64'hB300, 1, 1);
    cyc("R5",  0, 8'h00, 64'h0,    1, 8'hFF, 64'hB300, 1, 1);
    cyc("R5",  1, 8'hFF, 64'hA400, 1, 8'h00, 64'hB301, 1, 1);
    cyc("R5",  1, 8'hFF, 64'hA400, 1, 8'h08, 64'hB302, 1, 1);
    cyc("R5",  1, 8'hFF, 64'hA400, 0, 8'h00, 64'h0,    1, 1);
    cyc("R5",  1, 8'h01, 64'hA401, 0, 8'h00, 64'h0,    1, 1);

    // R9 idle drops non-header words
    cyc("R9", 1, 8'h00, 64'hC000, 1, 8'h02, 64'hC001, 1, 1);
    cyc("R9", 1, 8'h00, 64'hC002, 1, 8'hFF, 64'hB500, 1, 1);
    cyc("R9", 0, 8'h00, 64'h0,    1, 8'h01, 64'hB501, 1, 1);
    cyc("R9", 1, 8'h10, 64'hC003, 0, 8'h00, 64'h0,    1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule